// File: doc/BRIEF.md
# Serial Port Interrupt Request Gate

This block collects the interrupt causes of a byte-wide serial port and decides whether the port raises an interrupt request to the CPU. There are three causes: a frame finished transmitting, a frame finished receiving, and a receive error. Each arrives as a one-cycle pulse from the serial engine. Each cause has a sticky status flag and a software enable bit. All three share one 2-bit priority level.

A small register port gives software access to the block. Through it, software reads the flags, clears them by writing ones, and reads and writes the enables and the priority. Each cycle the block combines the pending enabled flags with the port priority and the CPU's current 2-bit mask level. From that it drives a request line, a code for the winning cause, and the vector address of that cause. The request output is combinational from the registered state, so it follows a flag or register update with no further delay.

Top module: `sif_irq_gate`

## Requirements
- R1: After reset, all flags, all enables and the priority read as zero, and no request is raised.
- R2: An event pulse sets its flag on the next clock edge, whatever its enable holds. Flag bit positions are bit 0 transmit done, bit 1 receive done, bit 2 receive error.
- R3: Writing the flag register at address 0 clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: When an event pulse and a clearing write hit the same flag in one cycle, the flag ends up set.
- R5: Address 1 holds the enables, in the same bit order as the flags. Address 2 holds the priority in bits 1:0. Both read back what was written, and unused bits read as 0.
- R6: A request is raised exactly when at least one flag is set with its enable at 1 and the priority is strictly greater than the CPU mask level.
- R7: A priority of 0 never raises a request.
- R8: When several enabled flags are pending, receive error wins over receive done, and receive done wins over transmit done. The cause code is 1 for transmit done, 2 for receive done and 3 for receive error.
- R9: The vector output is 0x000014 for transmit done, 0x000012 for receive done and 0x000010 for receive error. While no request is raised, both the vector and the cause code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_done_evt | input | 1 | One-cycle pulse: a transmit frame has fully shifted out |
| rx_done_evt | input | 1 | One-cycle pulse: a receive frame is complete |
| rx_err_evt | input | 1 | One-cycle pulse: a receive error was detected |
| cpu_mask | input | 2 | Current CPU interrupt mask level |
| reg_addr | input | 2 | Register select: 0 flags, 1 enables, 2 priority |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_cause | output | 2 | Winning cause code, 0 when idle |
| irq_vector | output | 24 | Vector address of the winning cause, 0 when idle |

## Verification
The bench builds the block with its default parameters. Those are three causes, a 2-bit priority compared against a 2-bit mask, 8-bit register data and 24-bit vectors. With these values every priority and mask pair at the edges can be reached: priority equal to the mask, priority one above the mask, and priority 0 against mask 0. All three causes can be pending together, so each precedence step can be removed one clear at a time. The 8-bit data path also leaves spare high bits, which show that the unused register bits read back as zero.

// File: rtl/sif_irq_pkg.sv
// Package: shared constants for the serial port interrupt gate.
// Assumes the cause index order below is also the precedence order,
// with the highest index winning.
package sif_irq_pkg;

    localparam int NUM_SRC  = 3;   // number of interrupt causes
    localparam int SRC_TX   = 0;   // transmit done flag/enable bit
    localparam int SRC_RX   = 1;   // receive done flag/enable bit
    localparam int SRC_ERR  = 2;   // receive error flag/enable bit

    localparam int REG_FLAGS  = 0; // write-one-to-clear status
    localparam int REG_ENABLE = 1; // per-cause enable bits
    localparam int REG_PRIO   = 2; // shared priority level

endpackage

// File: rtl/sif_irq_flags.sv
// Module: sif_irq_flags
// Holds one sticky status flag per cause. An event pulse sets its flag,
// and a write with a 1 in the flag's bit clears it. The set wins when both
// arrive in the same cycle. Assumes the event inputs are synchronous
// one-cycle pulses.
module sif_irq_flags #(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] flags
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        // Purpose: sticky flag i, with set taking precedence over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (evt[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_we && clr_mask[i]) begin
                flags[i] <= 1'b0;
            end
        end

        AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> flags[i]);                                          // R2
        AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[i] && clr_we && clr_mask[i]) |=> flags[i]);               // R4
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt[i] && clr_we && clr_mask[i]) |=> !flags[i]);             // R3
        AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt[i] && !(clr_we && clr_mask[i])) |=> $stable(flags[i]));  // R3
    end

endmodule

// File: rtl/sif_irq_ctrl.sv
// Module: sif_irq_ctrl
// Holds the software-written enable bits and the shared priority level,
// and drives the read-back multiplexer for all registers. Assumes one
// write per cycle, with the address decoded by the caller.
module sif_irq_ctrl #(
    parameter int NUM_SRC = 3,
    parameter int PRIO_W  = 2,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_we,
    input  logic               prio_we,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [NUM_SRC-1:0] flags,
    output logic [NUM_SRC-1:0] en,
    output logic [PRIO_W-1:0]  prio,
    output logic [DATA_W-1:0]  rdata
);
    import sif_irq_pkg::*;

    // Purpose: enable register, written from the low data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
        end else if (en_we) begin
            en <= wdata[NUM_SRC-1:0];
        end
    end

    // Purpose: shared priority level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio <= '0;
        end else if (prio_we) begin
            prio <= wdata[PRIO_W-1:0];
        end
    end

    // Purpose: register read-back with zero fill for unused bits.
    always_comb begin
        rdata = '0;
        case (rd_addr)
            ADDR_W'(REG_FLAGS):  rdata[NUM_SRC-1:0] = flags;
            ADDR_W'(REG_ENABLE): rdata[NUM_SRC-1:0] = en;
            ADDR_W'(REG_PRIO):   rdata[PRIO_W-1:0]  = prio;
            default:             rdata = '0;
        endcase
    end

    AST_PRIO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        prio_we |=> prio == $past(wdata[PRIO_W-1:0]));                     // R5
    AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !en_we |=> $stable(en));                                           // R5

endmodule

// File: rtl/sif_irq_arbiter.sv
// Module: sif_irq_arbiter
// Picks the highest-precedence enabled pending cause, gates it against
// the priority-versus-mask compare, and drives the request, the cause
// code and the vector. Assumes that a higher cause index means higher
// precedence. Purely combinational; the clock is used only by the checks.
module sif_irq_arbiter #(
    parameter int NUM_SRC = 3,
    parameter int PRIO_W  = 2,
    parameter int VEC_W   = 24,
    parameter logic [NUM_SRC-1:0][VEC_W-1:0] VEC_TABLE = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC-1:0]          flags,
    input  logic [NUM_SRC-1:0]          en,
    input  logic [PRIO_W-1:0]           prio,
    input  logic [PRIO_W-1:0]           mask,
    output logic                        req,
    output logic [$clog2(NUM_SRC+1)-1:0] cause,
    output logic [VEC_W-1:0]            vector
);
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int CAUSE_W = $clog2(NUM_SRC + 1);

    logic [NUM_SRC-1:0] pending;
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    logic               prio_ok;

    assign pending = flags & en;
    assign prio_ok = (prio > mask);

    // Purpose: scan upward so that the highest pending index wins.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pending[i]) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
            end
        end
    end

    // Purpose: final gate and output encoding, zero while idle.
    always_comb begin
        req    = win_valid && prio_ok;
        cause  = '0;
        vector = '0;
        if (req) begin
            cause  = CAUSE_W'(win_idx) + CAUSE_W'(1);
            vector = VEC_TABLE[win_idx];
        end
    end

    AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> ((flags & en) != '0));                                     // R6
    AST_PRIO_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (prio == '0) |-> !req);                                            // R7
    AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (req && flags[NUM_SRC-1] && en[NUM_SRC-1]) |-> (cause == CAUSE_W'(NUM_SRC))); // R8
    AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (vector == '0 && cause == '0));                           // R9

endmodule

// File: rtl/sif_irq_gate.sv
// Module: sif_irq_gate (top)
// Serial port interrupt gate: sticky cause flags, software enables and
// priority, and the request decision against the CPU mask level.
// Assumes event pulses are synchronous to clk and last one cycle.
module sif_irq_gate #(
    parameter int NUM_SRC = sif_irq_pkg::NUM_SRC,
    parameter int PRIO_W  = 2,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 2,
    parameter int VEC_W   = 24,
    parameter logic [VEC_W-1:0] VEC_TX  = 24'h000014,
    parameter logic [VEC_W-1:0] VEC_RX  = 24'h000012,
    parameter logic [VEC_W-1:0] VEC_ERR = 24'h000010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_done_evt,
    input  logic              rx_done_evt,
    input  logic              rx_err_evt,
    input  logic [PRIO_W-1:0] cpu_mask,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req,
    output logic [1:0]        irq_cause,
    output logic [VEC_W-1:0]  irq_vector
);
    import sif_irq_pkg::*;

    localparam logic [NUM_SRC-1:0][VEC_W-1:0] VEC_TABLE = {VEC_ERR, VEC_RX, VEC_TX};

    logic [NUM_SRC-1:0] evt;
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] en;
    logic [PRIO_W-1:0]  prio;
    logic               flags_we;
    logic               en_we;
    logic               prio_we;

    // Purpose: map the event pins onto cause indices.
    always_comb begin
        evt          = '0;
        evt[SRC_TX]  = tx_done_evt;
        evt[SRC_RX]  = rx_done_evt;
        evt[SRC_ERR] = rx_err_evt;
    end

    // Purpose: decode register writes by address.
    always_comb begin
        flags_we = reg_wr && (reg_addr == ADDR_W'(REG_FLAGS));
        en_we    = reg_wr && (reg_addr == ADDR_W'(REG_ENABLE));
        prio_we  = reg_wr && (reg_addr == ADDR_W'(REG_PRIO));
    end

    sif_irq_flags #(
        .NUM_SRC (NUM_SRC)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .clr_we   (flags_we),
        .clr_mask (reg_wdata[NUM_SRC-1:0]),
        .flags    (flags)
    );

    sif_irq_ctrl #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_we   (en_we),
        .prio_we (prio_we),
        .wdata   (reg_wdata),
        .rd_addr (reg_addr),
        .flags   (flags),
        .en      (en),
        .prio    (prio),
        .rdata   (reg_rdata)
    );

    sif_irq_arbiter #(
        .NUM_SRC   (NUM_SRC),
        .PRIO_W    (PRIO_W),
        .VEC_W     (VEC_W),
        .VEC_TABLE (VEC_TABLE)
    ) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .flags  (flags),
        .en     (en),
        .prio   (prio),
        .mask   (cpu_mask),
        .req    (irq_req),
        .cause  (irq_cause),
        .vector (irq_vector)
    );

    AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (prio > cpu_mask));                                    // R6
    AST_SET_DESPITE_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done_evt && !en[SRC_TX]) |=> flags[SRC_TX]);                  // R2

endmodule

// File: tb/sif_irq_gate_test.sv
module sif_irq_gate_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_done_evt = 1'b0;
    logic        rx_done_evt = 1'b0;
    logic        rx_err_evt = 1'b0;
    logic [1:0]  cpu_mask = 2'd0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        irq_req;
    logic [1:0]  irq_cause;
    logic [23:0] irq_vector;

    always #(CLK_PERIOD/2) clk = ~clk;

    sif_irq_gate uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_done_evt (tx_done_evt),
        .rx_done_evt (rx_done_evt),
        .rx_err_evt  (rx_err_evt),
        .cpu_mask    (cpu_mask),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq_req     (irq_req),
        .irq_cause   (irq_cause),
        .irq_vector  (irq_vector)
    );

    typedef struct {
        string       tag;
        bit          is_read;
        logic [7:0]  rd;
        logic        req;
        logic [1:0]  cause;
        logic [23:0] vec;
    } exp_t;

    exp_t scb[$];
    int   checks = 0;
    int   fails = 0;
    bit   done = 0;

    // Monitor: pops expected items and compares against the outputs.
    initial begin
        forever begin
            wait (scb.size() != 0);
            begin
                exp_t e;
                e = scb.pop_front();
                #1;
                checks++;
                if (e.is_read) begin
                    if (reg_rdata !== e.rd) begin
                        fails++;
                        $display("FAIL %s: rdata actual=%h expected=%h", e.tag, reg_rdata, e.rd);
                    end
                end else if (irq_req !== e.req || irq_cause !== e.cause || irq_vector !== e.vec) begin
                    fails++;
                    $display("FAIL %s: req/cause/vec actual=%b/%0d/%h expected=%b/%0d/%h",
                             e.tag, irq_req, irq_cause, irq_vector, e.req, e.cause, e.vec);
                end
            end
        end
    end

    task automatic exp_rd(input logic [1:0] a, input logic [7:0] v, input string tag);
        exp_t e;
        reg_addr = a;
        e.tag = tag; e.is_read = 1; e.rd = v; e.req = 0; e.cause = 0; e.vec = 0;
        scb.push_back(e);
        wait (scb.size() == 0);
        #2;
    endtask

    task automatic exp_irq(input logic r, input logic [1:0] c, input logic [23:0] v, input string tag);
        exp_t e;
        e.tag = tag; e.is_read = 0; e.rd = 0; e.req = r; e.cause = c; e.vec = v;
        scb.push_back(e);
        wait (scb.size() == 0);
        #2;
    endtask

    // Driver: one cycle of events and an optional register write.
    task automatic drive(input logic tx, input logic rx, input logic er,
                         input logic wr, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        tx_done_evt = tx; rx_done_evt = rx; rx_err_evt = er;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        tx_done_evt = 0; rx_done_evt = 0; rx_err_evt = 0; reg_wr = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        drive(0, 0, 0, 1, a, d);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        exp_rd(2'd0, 8'h00, "R1 flags");
        exp_rd(2'd1, 8'h00, "R1 enables");
        exp_rd(2'd2, 8'h00, "R1 prio");
        exp_irq(0, 0, 24'h0, "R1 idle");

        // R2 flag sets with enables off, no request
        drive(1, 0, 0, 0, 2'd0, 8'h00);
        exp_rd(2'd0, 8'h01, "R2 tx flag while disabled");
        exp_irq(0, 0, 24'h0, "R6 disabled cause no request");

        // R3 write 0 keeps, write 1 clears
        wr(2'd0, 8'h00);
        exp_rd(2'd0, 8'h01, "R3 write 0 keeps flag");
        wr(2'd0, 8'h01);
        exp_rd(2'd0, 8'h00, "R3 write 1 clears flag");

        // R5 register read-back
        wr(2'd1, 8'hFF);
        exp_rd(2'd1, 8'h07, "R5 enables readback");
        wr(2'd2, 8'hFF);
        exp_rd(2'd2, 8'h03, "R5 prio readback upper zero");
        wr(2'd2, 8'h00);

        // R7 priority 0 quiet
        drive(1, 0, 0, 0, 2'd0, 8'h00);
        exp_irq(0, 0, 24'h0, "R7 prio 0 no request");
        wr(2'd2, 8'h01);
        exp_irq(1, 2'd1, 24'h000014, "R9 tx vector prio1>mask0");
        cpu_mask = 2'd1;
        exp_irq(0, 0, 24'h0, "R6 prio equal mask blocks");
        wr(2'd2, 8'h03);
        cpu_mask = 2'd3;
        exp_irq(0, 0, 24'h0, "R6 prio3 mask3 blocks");
        cpu_mask = 2'd2;
        exp_irq(1, 2'd1, 24'h000014, "R6 prio3 mask2 requests");

        // R8 precedence
        drive(0, 1, 0, 0, 2'd0, 8'h00);
        exp_irq(1, 2'd2, 24'h000012, "R8 rx over tx");
        drive(0, 0, 1, 0, 2'd0, 8'h00);
        exp_irq(1, 2'd3, 24'h000010, "R8 err over rx");
        wr(2'd0, 8'h04);
        exp_irq(1, 2'd2, 24'h000012, "R8 rx after err cleared");
        wr(2'd0, 8'h02);
        exp_irq(1, 2'd1, 24'h000014, "R8 tx after rx cleared");
        wr(2'd1, 8'h06);
        exp_irq(0, 0, 24'h0, "R6 pending but disabled");
        exp_rd(2'd0, 8'h01, "R2 flag kept while disabled");
        wr(2'd1, 8'h04);
        drive(0, 0, 1, 0, 2'd0, 8'h00);
        exp_irq(1, 2'd3, 24'h000010, "R8 err alone enabled");

        // R4 set beats clear in the same cycle
        drive(0, 1, 0, 1, 2'd0, 8'h02);
        exp_rd(2'd0, 8'h07, "R4 set wins over clear");

        // R9 idle after clearing everything
        wr(2'd0, 8'h07);
        exp_rd(2'd0, 8'h00, "R3 clear all");
        exp_irq(0, 0, 24'h0, "R9 idle zeros");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule